// File: doc/BRIEF.md
# Twin-Predicated Element Pair Sequencer

This block walks the element positions of a two-operand vector operation (a move, a type conversion, a load or a store) and hands a downstream element datapath one (source index, destination index) pair per accepted transfer. Each side carries its own predicate mask. The block finds the next eligible source element and the next eligible destination element on its own for each side. Depending on how the two masks are set, the sequence of pairs forms a compress, an expand, a splat, an insert or an extract.

A one-cycle start pulse captures both masks, a 2-bit predication mode, the vector length and a starting element position. Pairs leave through a valid/ready handshake. Predication never zeroes anything: a masked-off destination position is simply never named, so the datapath leaves it untouched. The block exposes a progress index, so that an operation interrupted by a fault can be restarted without redoing completed elements. When either side runs out of eligible elements below the vector length, the block raises a one-cycle completion pulse and goes idle.

Top module: `twin_pred_seq`

## Requirements
- R1: With mode 2'b00 neither mask is consulted; the pairs are (k, k) for k counting up by one from the start position to the vector length minus one.
- R2: With mode 2'b01 only the source mask applies (bit i of the mask enables element i): the source index steps to the next set bit, while the destination index steps by exactly one per pair.
- R3: With mode 2'b10 only the destination mask applies: the destination index steps to the next set bit, while the source index steps by exactly one per pair.
- R4: With mode 2'b11 both masks apply, and each index jumps to the next set bit of its own mask without regard to the other.
- R5: While pair_valid_o is high and pair_ready_i is low, the presented pair stays unchanged; the indices move on only when a transfer completes.
- R6: The operation ends as soon as either side has no eligible element at or above its cursor and below the vector length, including at once for a zero length or an empty mask in use; no further pair is offered, done_o is high for exactly one cycle, and busy_o is low in that cycle.
- R7: A start pulse that arrives while busy_o is high has no effect on the pairs still to come.
- R8: resume_idx_o equals the start position right after a start and, after each transfer, one more than the source index of that transfer.
- R9: Both sides begin scanning at the start position; lower elements are never offered.
- R10: A vector length above the mask width is treated as the mask width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| src_mask_i | input | VLMAX | Source predicate, bit i enables element i |
| dst_mask_i | input | VLMAX | Destination predicate, bit i enables element i |
| mode_i | input | 2 | Bit 0 enables the source mask, bit 1 enables the destination mask |
| vl_i | input | IDX_W | Vector length |
| start_idx_i | input | IDX_W | First element position for both sides |
| pair_valid_o | output | 1 | A pair is being offered |
| pair_ready_i | input | 1 | Downstream accepts the offered pair |
| src_idx_o | output | IDX_W | Source element index of the pair |
| dst_idx_o | output | IDX_W | Destination element index of the pair |
| resume_idx_o | output | IDX_W | Progress position for a restart |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a start pulse landing in the middle of a running operation while the downstream side is also stalling. A pulse like that must leave the remaining sequence and the progress index untouched. The table-driven bench covers this by letting a row inject a second start with very different masks, mode and length at a chosen cycle, while an 8-bit ready pattern mixes stalls with transfers. The same ready patterns hold a pair under back-pressure, so stability is checked across several held cycles. Rows with zero length, an empty mask, and a length that exceeds the mask width force the end-of-operation path without any transfer or at the clamp.

// File: rtl/twin_pred_pkg.sv
package twin_pred_pkg;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_SRC  = 0;
    localparam int SIDE_DST  = 1;

    typedef enum logic [1:0] {
        PM_NONE = 2'b00,
        PM_SRC  = 2'b01,
        PM_DST  = 2'b10,
        PM_TWIN = 2'b11
    } pred_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Whether the given side consults its mask under a mode.
    function automatic logic side_masked(input pred_mode_e mode, input int side);
        logic [1:0] bits;
        bits = mode;
        return (side == SIDE_SRC) ? bits[0] : bits[1];
    endfunction

    // Clamp a requested length to the mask width.
    function automatic int unsigned clamp_len(input int unsigned req, input int unsigned cap);
        return (req > cap) ? cap : req;
    endfunction

endpackage

// File: rtl/tp_scan.sv
module tp_scan #(
    parameter int VLMAX = 16,
    parameter int IDX_W = $clog2(VLMAX + 1)
) (
    input  logic [VLMAX-1:0] mask,
    input  logic             use_mask,
    input  logic [IDX_W-1:0] from,
    input  logic [IDX_W-1:0] limit,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [VLMAX-1:0] eligible;

    // Per-position eligibility: inside [from, limit) and enabled.
    for (genvar g = 0; g < VLMAX; g++) begin : g_elig
        localparam logic [IDX_W-1:0] POS = IDX_W'(g);
        assign eligible[g] = (POS >= from) && (POS < limit) && (!use_mask || mask[g]);
    end

    // Lowest eligible position wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = VLMAX - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tp_lane.sv
module tp_lane #(
    parameter int VLMAX = 16,
    parameter int IDX_W = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [VLMAX-1:0] init_mask,
    input  logic [IDX_W-1:0] init_pos,
    input  logic             use_mask,
    input  logic [IDX_W-1:0] limit,
    input  logic             advance,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] cursor
);

    logic [VLMAX-1:0] mask_q;
    logic [IDX_W-1:0] cursor_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            cursor_q <= '0;
        end else if (load) begin
            mask_q   <= init_mask;
            cursor_q <= init_pos;
        end else if (advance) begin
            cursor_q <= idx + IDX_W'(1);
        end
    end

    tp_scan #(.VLMAX(VLMAX), .IDX_W(IDX_W)) scan_i (
        .mask     (mask_q),
        .use_mask (use_mask),
        .from     (cursor_q),
        .limit    (limit),
        .found    (found),
        .idx      (idx)
    );

    assign cursor = cursor_q;

    // R5: the cursor moves only on a load or a completed transfer.
    a_r5_cursor_holds: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(cursor_q))
        else $error("cursor moved without transfer");

    // R4: every transfer moves the cursor strictly forward.
    a_r4_cursor_climbs: assert property (@(posedge clk) disable iff (rst)
        (advance && !load) |=> (cursor_q > $past(cursor_q)))
        else $error("cursor did not climb");

    // R9: an offered index is never below the cursor.
    a_r9_not_below_cursor: assert property (@(posedge clk) disable iff (rst)
        found |-> (idx >= cursor_q))
        else $error("index below cursor");

endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl
    import twin_pred_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic both_found,
    input  logic ready,
    output logic busy,
    output logic valid,
    output logic advance,
    output logic load,
    output logic done
);

    seq_state_e state_q;
    logic       done_q;

    assign busy    = (state_q == ST_RUN);
    assign load    = start && (state_q == ST_IDLE);
    assign valid   = busy && both_found;
    assign advance = valid && ready;
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) state_q <= ST_RUN;
                ST_RUN: begin
                    if (!both_found) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R6: completion lasts a single cycle.
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q)
        else $error("done longer than one cycle");

    // R6: completion follows a running cycle that had no pair.
    a_r6_done_after_run: assert property (@(posedge clk) disable iff (rst)
        (busy && !both_found) |=> (done_q && !busy))
        else $error("end of operation not flagged");

    // R7: a start while running leaves the controller running.
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && both_found && start) |=> busy)
        else $error("start disturbed a running operation");

endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq
    import twin_pred_pkg::*;
#(
    parameter int VLMAX = 16,
    parameter int IDX_W = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [VLMAX-1:0] src_mask_i,
    input  logic [VLMAX-1:0] dst_mask_i,
    input  logic [1:0]       mode_i,
    input  logic [IDX_W-1:0] vl_i,
    input  logic [IDX_W-1:0] start_idx_i,
    output logic             pair_valid_o,
    input  logic             pair_ready_i,
    output logic [IDX_W-1:0] src_idx_o,
    output logic [IDX_W-1:0] dst_idx_o,
    output logic [IDX_W-1:0] resume_idx_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] VL_CAP = IDX_W'(VLMAX);

    pred_mode_e       mode_q;
    logic [IDX_W-1:0] vl_q;

    logic             load;
    logic             advance;
    logic             valid;
    logic             busy;

    logic [NUM_SIDES-1:0][VLMAX-1:0] init_mask;
    logic [NUM_SIDES-1:0]            side_found;
    logic [NUM_SIDES-1:0]            side_use;
    logic [IDX_W-1:0]                side_idx    [NUM_SIDES];
    logic [IDX_W-1:0]                side_cursor [NUM_SIDES];

    assign init_mask[SIDE_SRC] = src_mask_i;
    assign init_mask[SIDE_DST] = dst_mask_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_NONE;
            vl_q   <= '0;
        end else if (load) begin
            mode_q <= pred_mode_e'(mode_i);
            vl_q   <= (vl_i > VL_CAP) ? VL_CAP : vl_i;
        end
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        assign side_use[s] = side_masked(mode_q, s);

        tp_lane #(.VLMAX(VLMAX), .IDX_W(IDX_W)) lane_i (
            .clk       (clk),
            .rst       (rst),
            .load      (load),
            .init_mask (init_mask[s]),
            .init_pos  (start_idx_i),
            .use_mask  (side_use[s]),
            .limit     (vl_q),
            .advance   (advance),
            .found     (side_found[s]),
            .idx       (side_idx[s]),
            .cursor    (side_cursor[s])
        );
    end

    tp_ctrl ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .both_found (&side_found),
        .ready      (pair_ready_i),
        .busy       (busy),
        .valid      (valid),
        .advance    (advance),
        .load       (load),
        .done       (done_o)
    );

    assign pair_valid_o = valid;
    assign busy_o       = busy;
    assign src_idx_o    = side_idx[SIDE_SRC];
    assign dst_idx_o    = side_idx[SIDE_DST];
    assign resume_idx_o = side_cursor[SIDE_SRC];

    // R5: an offered pair is held under back-pressure.
    a_r5_pair_stable: assert property (@(posedge clk) disable iff (rst)
        (pair_valid_o && !pair_ready_i) |=>
            (pair_valid_o && $stable(src_idx_o) && $stable(dst_idx_o)))
        else $error("pair changed while stalled");

    // R1: without predication both indices move in lockstep.
    a_r1_lockstep: assert property (@(posedge clk) disable iff (rst)
        (pair_valid_o && mode_q == PM_NONE) |-> (src_idx_o == dst_idx_o))
        else $error("unpredicated indices diverged");

    // R10: offered indices stay below the clamped length.
    a_r10_in_range: assert property (@(posedge clk) disable iff (rst)
        pair_valid_o |-> ((src_idx_o < vl_q) && (dst_idx_o < vl_q) && (vl_q <= VL_CAP)))
        else $error("index beyond length");

    // R8: progress position follows the accepted source index.
    a_r8_resume_follows: assert property (@(posedge clk) disable iff (rst)
        (pair_valid_o && pair_ready_i) |=> (resume_idx_o == $past(src_idx_o) + IDX_W'(1)))
        else $error("progress index wrong");

endmodule

// File: tb/twin_pred_seq_tb_top.sv
module twin_pred_seq_tb_top;

    localparam int VLMAX = 16;
    localparam int IDX_W = 5;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] sm;
        logic [15:0] dm;
        logic [4:0]  vl;
        logic [4:0]  vs;
        logic [7:0]  rdy;
        logic [7:0]  inj;
    } row_t;

    localparam int NROWS = 11;
    localparam row_t ROWS [NROWS] = '{
        '{2'd0, 16'hFFFF, 16'hFFFF, 5'd8,  5'd0, 8'hFF,        8'd0},
        '{2'd0, 16'h0000, 16'h0000, 5'd10, 5'd3, 8'b1010_0110, 8'd0},
        '{2'd1, 16'hA5A5, 16'h0000, 5'd16, 5'd0, 8'hFF,        8'd0},
        '{2'd2, 16'h0000, 16'h0F0C, 5'd16, 5'd0, 8'b1101_1011, 8'd0},
        '{2'd3, 16'h00F1, 16'h8421, 5'd16, 5'd0, 8'hFF,        8'd0},
        '{2'd3, 16'h0013, 16'hFFF0, 5'd12, 5'd0, 8'b0111_0111, 8'd0},
        '{2'd3, 16'hFFFF, 16'h0FF0, 5'd16, 5'd6, 8'b0110_1101, 8'd0},
        '{2'd0, 16'h0000, 16'h0000, 5'd20, 5'd0, 8'hFF,        8'd0},
        '{2'd0, 16'hFFFF, 16'hFFFF, 5'd0,  5'd0, 8'hFF,        8'd0},
        '{2'd3, 16'h0000, 16'hFFFF, 5'd16, 5'd0, 8'hFF,        8'd0},
        '{2'd0, 16'h0000, 16'h0000, 5'd12, 5'd0, 8'b1011_1101, 8'd3}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [15:0]      src_mask_i = '0;
    logic [15:0]      dst_mask_i = '0;
    logic [1:0]       mode_i = '0;
    logic [IDX_W-1:0] vl_i = '0;
    logic [IDX_W-1:0] start_idx_i = '0;
    logic             pair_ready_i = 1'b0;
    logic             pair_valid_o;
    logic [IDX_W-1:0] src_idx_o;
    logic [IDX_W-1:0] dst_idx_o;
    logic [IDX_W-1:0] resume_idx_o;
    logic             busy_o;
    logic             done_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    twin_pred_seq #(.VLMAX(VLMAX), .IDX_W(IDX_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .src_mask_i   (src_mask_i),
        .dst_mask_i   (dst_mask_i),
        .mode_i       (mode_i),
        .vl_i         (vl_i),
        .start_idx_i  (start_idx_i),
        .pair_valid_o (pair_valid_o),
        .pair_ready_i (pair_ready_i),
        .src_idx_o    (src_idx_o),
        .dst_idx_o    (dst_idx_o),
        .resume_idx_o (resume_idx_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Next enabled position in [from, lim), or -1.
    function automatic int next_pos(input logic [15:0] m, input bit use_m, input int from, input int lim);
        for (int i = from; i < lim; i++)
            if (!use_m || m[i]) return i;
        return -1;
    endfunction

    task automatic run_op(input row_t r);
        int  s, d, ns, nd, vle, pairs;
        bit  seen_done, prev_stall, exp_v;
        int  prev_s, prev_d;
        vle = (r.vl > 16) ? 16 : int'(r.vl);   // R10 clamp
        @(negedge clk);
        start_i = 1'b1; src_mask_i = r.sm; dst_mask_i = r.dm;
        mode_i = r.mode; vl_i = r.vl; start_idx_i = r.vs; pair_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        s = int'(r.vs); d = int'(r.vs);   // R9 both sides start here
        seen_done = 0; prev_stall = 0; prev_s = 0; prev_d = 0; pairs = 0;
        for (int cyc = 0; cyc < 80 && !seen_done; cyc++) begin
            if (r.inj != 0 && cyc == int'(r.inj)) begin
                // R7: disruptive start while running
                start_i = 1'b1; src_mask_i = 16'h0000; dst_mask_i = 16'h0001;
                mode_i = 2'd3; vl_i = 5'd2; start_idx_i = 5'd1;
            end else begin
                start_i = 1'b0;
            end
            pair_ready_i = r.rdy[cyc % 8];
            #1;
            ns = next_pos(r.sm, r.mode[0], s, vle);
            nd = next_pos(r.dm, r.mode[1], d, vle);
            exp_v = (ns >= 0) && (nd >= 0);
            if (done_o) begin
                seen_done = 1;
                chk(!exp_v, "R6 done with pairs left", 1, 0);
                chk(busy_o == 1'b0, "R6 busy at done", int'(busy_o), 0);
                chk(pairs > 0 || !exp_v, "R6 pair count", pairs, 0);
            end else begin
                chk(pair_valid_o == exp_v, r.inj != 0 ? "R7 valid" : "R6 valid",
                    int'(pair_valid_o), int'(exp_v));
                if (pair_valid_o && exp_v) begin
                    chk(int'(src_idx_o) == ns, {mode_tag(r.mode), " src"}, int'(src_idx_o), ns);
                    chk(int'(dst_idx_o) == nd, {mode_tag(r.mode), " dst"}, int'(dst_idx_o), nd);
                end
                if (prev_stall) begin
                    chk(int'(src_idx_o) == prev_s, "R5 src held", int'(src_idx_o), prev_s);
                    chk(int'(dst_idx_o) == prev_d, "R5 dst held", int'(dst_idx_o), prev_d);
                end
            end
            chk(int'(resume_idx_o) == s, "R8 resume", int'(resume_idx_o), s);
            prev_stall = pair_valid_o && !pair_ready_i;
            prev_s = int'(src_idx_o); prev_d = int'(dst_idx_o);
            if (pair_valid_o && pair_ready_i && exp_v) begin
                s = ns + 1; d = nd + 1; pairs++;
            end
            @(negedge clk);
        end
        start_i = 1'b0; pair_ready_i = 1'b0;
        chk(seen_done, "R6 done seen", int'(seen_done), 1);
        #1;
        chk(done_o == 1'b0, "R6 done one cycle", int'(done_o), 0);
        chk(pair_valid_o == 1'b0, "R6 no pair after end", int'(pair_valid_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(pair_valid_o == 1'b0, "R6 reset valid", int'(pair_valid_o), 0);
        chk(busy_o == 1'b0, "R6 reset busy", int'(busy_o), 0);
        chk(done_o == 1'b0, "R6 reset done", int'(done_o), 0);
        chk(resume_idx_o == '0, "R8 reset resume", int'(resume_idx_o), 0);
        for (int k = 0; k < NROWS; k++) run_op(ROWS[k]);
        // Directed: R10 clamp yields exactly VLMAX lockstep pairs (row 7 covered);
        // Directed: start index at the length gives no pair (R9, R6).
        run_op('{2'd1, 16'hFFFF, 16'hFFFF, 5'd8, 5'd8, 8'hFF, 8'd0});
        // Directed: R2 with destination mask ignored, last source element only.
        run_op('{2'd1, 16'h8000, 16'h0000, 5'd16, 5'd2, 8'b0101_0101, 8'd0});
        // Directed: R3 destination near the end, source counting from start.
        run_op('{2'd2, 16'h0000, 16'hC000, 5'd16, 5'd5, 8'hFF, 8'd0});
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule